// File: doc/BRIEF.md
# Multi-LED Link and Activity Indicator Controller

This block drives a small set of indicator LEDs (three by default) from the state of an Ethernet link. Each LED has two 16-bit configuration words. The steady word selects which link conditions keep the LED lit: link speed, link down and duplex. The flash word selects which traffic or error pulses make the LED flash: per-speed transmit and receive activity, collision, CRC error and idle error. Each LED also has an enable bit, a polarity bit, a force-lit bit and a force-flash bit.

A shared control word decides whether the LEDs are driven at all. It also gates the flash timebase and offers a fast-timer test bit. Two duration words set the flash period and the lit part of each flash, both counted in timebase units of `TICK_UNIT` clocks.

A flash cycle starts on a selected event. It overrides the steady state until the cycle finishes. Further events during a cycle queue one more full cycle without moving the current phase. Every LED output is registered.

Top module: `led_status_ctrl`

## Requirements
- R1: After reset all configuration words are zero, the flash period word is 2 and the lit-duration word is 1, and every `led_o` bit is 1 (the inactive level for the reset polarity, active low).
- R2: The control word is at address 0x00, with bits 1:0 the mode, bit 2 the fast-timer test bit, bit 3 the timebase enable and bit 15 the external-drive enable. LEDs are driven only when bit 3 is set and either bit 15 is set or the mode is nonzero; otherwise every output sits at its inactive level.
- R3: Bit 14 of an LED's steady word is its polarity. When it is set the pin is high while lit; when it is clear the pin is low while lit, and the inactive level is the opposite.
- R4: Steady-word condition bits are: bit 0 link up at 1000, bit 1 at 100, bit 2 at 10, bit 8 at 2500, bit 3 link down, bit 4 link up in full duplex, bit 5 link up in half duplex. `link_speed` encodes 0=10, 1=100, 2=1000, 3=2500. A lit LED needs bit 15 (enable) set and at least one selected condition true.
- R5: Steady-word bit 6 (force lit) lights an enabled LED whatever the link state.
- R6: An LED whose enable bit 15 is clear sits at its inactive level, whatever its other bits say.
- R7: Flash-word event bits are: bit 0/1 tx/rx at 1000, bit 2/3 tx/rx at 100, bit 4/5 tx/rx at 10, bit 10/11 tx/rx at 2500, bit 6 collision, bit 7 CRC error, bit 8 idle error. A selected event starts a flash cycle that is lit for the lit-duration (address 0x02) and dark for the rest of the flash period (address 0x01), overriding the steady state. Unselected events have no effect.
- R8: A selected event during an active flash cycle does not restart its phase. Exactly one further full cycle follows the current one.
- R9: Flash-word bit 9 (force flash) makes an enabled LED flash continuously at the flash period.
- R10: One duration unit lasts `TICK_UNIT` clocks. With the fast-timer test bit set, one unit lasts one clock.
- R11: `led_o` is registered: it reflects configuration and inputs sampled at the previous rising edge.
- R12: LED i has its steady word at address 0x04+2*i and its flash word at 0x05+2*i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 16 | Register write data |
| link_up | input | 1 | Link is up |
| link_speed | input | 2 | Current speed: 0=10, 1=100, 2=1000, 3=2500 |
| full_duplex | input | 1 | Link is full duplex |
| tx_act | input | 4 | Transmit activity pulse per speed (index as link_speed) |
| rx_act | input | 4 | Receive activity pulse per speed (index as link_speed) |
| collision | input | 1 | Collision pulse |
| crc_err | input | 1 | Receive CRC error pulse |
| idle_err | input | 1 | Receive idle error pulse |
| led_o | output | NUM_LEDS | LED pins |

## Verification
The assertions take it that reset is applied synchronously before the first configuration write. They also take it that the enable, polarity and force bits seen by the checker are the register contents, so a change to any of them shows on the pin exactly one edge later. The stimulus changes inputs and performs writes only on falling edges, and it holds each event pulse for whole clock cycles. It also lets any flash cycle end before the next scenario reconfigures the durations, so no period is shortened under a running phase.

// File: rtl/led_ctrl_pkg.sv
package led_ctrl_pkg;
  localparam int REG_W = 16;

  // steady word bit positions
  localparam int SB_L1000 = 0;
  localparam int SB_L100  = 1;
  localparam int SB_L10   = 2;
  localparam int SB_DOWN  = 3;
  localparam int SB_FDX   = 4;
  localparam int SB_HDX   = 5;
  localparam int SB_FORCE = 6;
  localparam int SB_L2500 = 8;
  localparam int SB_POL   = 14;
  localparam int SB_EN    = 15;

  // flash word bit positions
  localparam int FB_TX1000 = 0;
  localparam int FB_RX1000 = 1;
  localparam int FB_TX100  = 2;
  localparam int FB_RX100  = 3;
  localparam int FB_TX10   = 4;
  localparam int FB_RX10   = 5;
  localparam int FB_COL    = 6;
  localparam int FB_CRC    = 7;
  localparam int FB_IDLE   = 8;
  localparam int FB_FORCE  = 9;
  localparam int FB_TX2500 = 10;
  localparam int FB_RX2500 = 11;

  typedef enum logic [1:0] {
    SPD_10 = 2'd0, SPD_100 = 2'd1, SPD_1000 = 2'd2, SPD_2500 = 2'd3
  } link_speed_e;

  // steady conditions currently true, placed at their steady-word positions
  function automatic logic [REG_W-1:0] cond_vector(input logic up,
                                                   input logic [1:0] spd,
                                                   input logic fdx);
    logic [REG_W-1:0] v;
    v = '0;
    v[SB_L10]   = up && (spd == SPD_10);
    v[SB_L100]  = up && (spd == SPD_100);
    v[SB_L1000] = up && (spd == SPD_1000);
    v[SB_L2500] = up && (spd == SPD_2500);
    v[SB_DOWN]  = !up;
    v[SB_FDX]   = up && fdx;
    v[SB_HDX]   = up && !fdx;
    return v;
  endfunction

  // event pulses placed at their flash-word positions
  function automatic logic [REG_W-1:0] event_vector(input logic [3:0] tx,
                                                    input logic [3:0] rx,
                                                    input logic col,
                                                    input logic crc,
                                                    input logic idle);
    logic [REG_W-1:0] v;
    v = '0;
    v[FB_TX10]   = tx[0];
    v[FB_RX10]   = rx[0];
    v[FB_TX100]  = tx[1];
    v[FB_RX100]  = rx[1];
    v[FB_TX1000] = tx[2];
    v[FB_RX1000] = rx[2];
    v[FB_TX2500] = tx[3];
    v[FB_RX2500] = rx[3];
    v[FB_COL]    = col;
    v[FB_CRC]    = crc;
    v[FB_IDLE]   = idle;
    return v;
  endfunction

  localparam logic [REG_W-1:0] STEADY_MASK = 16'h013F;
  localparam logic [REG_W-1:0] EVENT_MASK  = 16'h0DFF;
endpackage

// File: rtl/led_regfile.sv
module led_regfile
  import led_ctrl_pkg::*;
#(
  parameter int NUM_LEDS = 3,
  parameter int AW = 8,
  parameter logic [AW-1:0] A_CTRL = 8'h00,
  parameter logic [AW-1:0] A_PERIOD = 8'h01,
  parameter logic [AW-1:0] A_LIT = 8'h02,
  parameter logic [AW-1:0] A_LED = 8'h04,
  parameter logic [REG_W-1:0] PERIOD_RST = 16'd2
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic [1:0] mode_q,
  output logic fast_q,
  output logic tb_en_q,
  output logic ext_q,
  output logic [REG_W-1:0] period_q,
  output logic [REG_W-1:0] lit_q,
  output logic [NUM_LEDS-1:0][REG_W-1:0] steady_q,
  output logic [NUM_LEDS-1:0][REG_W-1:0] flash_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      fast_q   <= 1'b0;
      tb_en_q  <= 1'b0;
      ext_q    <= 1'b0;
      period_q <= PERIOD_RST;
      lit_q    <= PERIOD_RST >> 1;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) begin
        mode_q  <= wr_data[1:0];
        fast_q  <= wr_data[2];
        tb_en_q <= wr_data[3];
        ext_q   <= wr_data[15];
      end
      if (wr_addr == A_PERIOD) period_q <= wr_data;
      if (wr_addr == A_LIT)    lit_q    <= wr_data;
    end
  end

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    localparam logic [AW-1:0] A_ST = A_LED + AW'(2 * i);
    localparam logic [AW-1:0] A_FL = A_LED + AW'(2 * i + 1);
    always_ff @(posedge clk) begin
      if (rst) begin
        steady_q[i] <= '0;
        flash_q[i]  <= '0;
      end else if (wr_en) begin
        if (wr_addr == A_ST) steady_q[i] <= wr_data;
        if (wr_addr == A_FL) flash_q[i]  <= wr_data;
      end
    end
  end
endmodule

// File: rtl/led_timebase.sv
module led_timebase #(
  parameter int TICK_UNIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  output logic unit_tick
);
  localparam int CW = (TICK_UNIT > 2) ? $clog2(TICK_UNIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_UNIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign unit_tick = run && (fast || (cnt == LAST));
endmodule

// File: rtl/led_channel.sv
module led_channel
  import led_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic glob_en,
  input  logic unit_tick,
  input  logic [REG_W-1:0] steady_cfg,
  input  logic [REG_W-1:0] flash_cfg,
  input  logic [REG_W-1:0] period,
  input  logic [REG_W-1:0] lit_len,
  input  logic [REG_W-1:0] conds,
  input  logic [REG_W-1:0] events,
  output logic flash_active,
  output logic led_pin
);
  logic en, pol, steady_lit, evt, frc, period_end, lit, pend;
  logic [REG_W-1:0] phase;

  assign en  = steady_cfg[SB_EN];
  assign pol = steady_cfg[SB_POL];
  assign steady_lit = en && (steady_cfg[SB_FORCE] ||
                             (|(steady_cfg & conds & STEADY_MASK)));
  assign evt = en && (|(flash_cfg & events & EVENT_MASK));
  assign frc = en && flash_cfg[FB_FORCE];
  assign period_end = unit_tick &&
                      (({1'b0, phase} + 17'd1) >= {1'b0, period});

  always_ff @(posedge clk) begin
    if (rst || !glob_en) begin
      flash_active <= 1'b0;
      pend  <= 1'b0;
      phase <= '0;
    end else if (!flash_active) begin
      if (evt || frc) begin
        flash_active <= 1'b1;
        phase <= '0;
        pend  <= 1'b0;
      end
    end else if (period_end) begin
      phase <= '0;
      pend  <= 1'b0;
      if (!(pend || evt || frc)) flash_active <= 1'b0;
    end else begin
      if (unit_tick) phase <= phase + 1'b1;
      if (evt) pend <= 1'b1;
    end
  end

  assign lit = en && (flash_active ? (phase < lit_len) : steady_lit);

  always_ff @(posedge clk) begin
    if (rst) led_pin <= 1'b1;
    else if (!glob_en) led_pin <= !pol;
    else led_pin <= pol ? lit : !lit;
  end
endmodule

// File: rtl/led_status_ctrl.sv
module led_status_ctrl
  import led_ctrl_pkg::*;
#(
  parameter int NUM_LEDS = 3,
  parameter int AW = 8,
  parameter int TICK_UNIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0] wr_data,
  input  logic link_up,
  input  logic [1:0] link_speed,
  input  logic full_duplex,
  input  logic [3:0] tx_act,
  input  logic [3:0] rx_act,
  input  logic collision,
  input  logic crc_err,
  input  logic idle_err,
  output logic [NUM_LEDS-1:0] led_o
);
  logic [1:0] mode_q;
  logic fast_q, tb_en_q, ext_q, glob_en, unit_tick;
  logic [REG_W-1:0] period_q, lit_q, conds, events;
  logic [NUM_LEDS-1:0][REG_W-1:0] steady_q, flash_q;
  logic [NUM_LEDS-1:0] flash_active, led_en_v, led_pol_v, led_frc_v;

  led_regfile #(.NUM_LEDS(NUM_LEDS), .AW(AW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_q(mode_q), .fast_q(fast_q),
    .tb_en_q(tb_en_q), .ext_q(ext_q), .period_q(period_q),
    .lit_q(lit_q), .steady_q(steady_q), .flash_q(flash_q)
  );

  assign glob_en = tb_en_q && (ext_q || (mode_q != 2'b00));

  led_timebase #(.TICK_UNIT(TICK_UNIT)) tbase_i (
    .clk(clk), .rst(rst), .run(glob_en), .fast(fast_q),
    .unit_tick(unit_tick)
  );

  assign conds  = cond_vector(link_up, link_speed, full_duplex);
  assign events = event_vector(tx_act, rx_act, collision, crc_err, idle_err);

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_ch
    assign led_en_v[i]  = steady_q[i][SB_EN];
    assign led_pol_v[i] = steady_q[i][SB_POL];
    assign led_frc_v[i] = steady_q[i][SB_FORCE];
    led_channel ch_i (
      .clk(clk), .rst(rst), .glob_en(glob_en), .unit_tick(unit_tick),
      .steady_cfg(steady_q[i]), .flash_cfg(flash_q[i]),
      .period(period_q), .lit_len(lit_q), .conds(conds),
      .events(events), .flash_active(flash_active[i]),
      .led_pin(led_o[i])
    );
  end
endmodule

// File: rtl/led_status_ctrl_chk.sv
module led_status_ctrl_chk #(
  parameter int NUM_LEDS = 3
) (
  input logic clk,
  input logic rst,
  input logic glob_en,
  input logic fast,
  input logic unit_tick,
  input logic [NUM_LEDS-1:0] led_en,
  input logic [NUM_LEDS-1:0] led_pol,
  input logic [NUM_LEDS-1:0] led_frc,
  input logic [NUM_LEDS-1:0] flash_active,
  input logic [NUM_LEDS-1:0] led_o
);
  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_a
    assert_gate_off_R2: assert property (@(posedge clk) disable iff (rst)
      !glob_en |=> (led_o[i] == !$past(led_pol[i])));
    assert_disabled_idle_R6: assert property (@(posedge clk) disable iff (rst)
      (glob_en && !led_en[i]) |=> (led_o[i] == !$past(led_pol[i])));
    assert_force_lit_R5: assert property (@(posedge clk) disable iff (rst)
      (glob_en && led_en[i] && led_frc[i] && !flash_active[i])
      |=> (led_o[i] == $past(led_pol[i])));
    assert_flash_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(flash_active[i]) |-> $past(glob_en && led_en[i]));
  end

  assert_fast_unit_R10: assert property (@(posedge clk) disable iff (rst)
    (glob_en && fast) |-> unit_tick);
endmodule

bind led_status_ctrl led_status_ctrl_chk #(.NUM_LEDS(NUM_LEDS)) chk_i (
  .clk(clk), .rst(rst), .glob_en(glob_en), .fast(fast_q),
  .unit_tick(unit_tick), .led_en(led_en_v), .led_pol(led_pol_v),
  .led_frc(led_frc_v), .flash_active(flash_active), .led_o(led_o)
);

// File: tb/led_status_ctrl_tb_top.sv
module led_status_ctrl_tb_top;
  localparam int N = 3;
  localparam int TU = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic link_up = 1'b0;
  logic [1:0] link_speed = '0;
  logic full_duplex = 1'b0;
  logic [3:0] tx_act = '0;
  logic [3:0] rx_act = '0;
  logic collision = 1'b0, crc_err = 1'b0, idle_err = 1'b0;
  logic [N-1:0] led_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  led_status_ctrl #(.NUM_LEDS(N), .AW(8), .TICK_UNIT(TU)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .link_up(link_up), .link_speed(link_speed),
    .full_duplex(full_duplex), .tx_act(tx_act), .rx_act(rx_act),
    .collision(collision), .crc_err(crc_err), .idle_err(idle_err),
    .led_o(led_o)
  );

  // {steady word, link_up, speed, fdx, expected lit, pad}
  localparam logic [23:0] VEC [12] = '{
    {16'hC001, 1'b1, 2'd2, 1'b0, 1'b1, 3'd0},
    {16'hC001, 1'b1, 2'd1, 1'b0, 1'b0, 3'd0},
    {16'hC002, 1'b1, 2'd1, 1'b0, 1'b1, 3'd0},
    {16'hC004, 1'b1, 2'd0, 1'b0, 1'b1, 3'd0},
    {16'hC100, 1'b1, 2'd3, 1'b0, 1'b1, 3'd0},
    {16'hC100, 1'b0, 2'd3, 1'b0, 1'b0, 3'd0},
    {16'hC008, 1'b0, 2'd0, 1'b0, 1'b1, 3'd0},
    {16'hC008, 1'b1, 2'd0, 1'b0, 1'b0, 3'd0},
    {16'hC010, 1'b1, 2'd2, 1'b1, 1'b1, 3'd0},
    {16'hC020, 1'b1, 2'd2, 1'b1, 1'b0, 3'd0},
    {16'hC020, 1'b1, 2'd2, 1'b0, 1'b1, 3'd0},
    {16'hC010, 1'b0, 2'd2, 1'b1, 1'b0, 3'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    logic [1:0] flash_exp4 [4];
    logic ext9 [9];
    logic prev;
    int run_len;

    idle(3);
    rst = 1'b0;
    idle(1);
    // R1: reset state, active-low default polarity inactive high
    chk(led_o == 3'b111, "R1 reset outputs", led_o, 7);

    // R2: global gating off with ctrl clear
    wr(8'h04, 16'hC040);
    idle(2);
    chk(led_o[0] == 1'b0, "R2 ctrl clear keeps inactive", led_o[0], 0);
    wr(8'h00, 16'h8008);
    idle(1);
    // R11: registered, one edge after the write took effect
    chk(led_o[0] == 1'b1, "R11 one-cycle output latency", led_o[0], 1);
    wr(8'h00, 16'h0009);
    idle(1);
    chk(led_o[0] == 1'b1, "R2 nonzero mode enables", led_o[0], 1);
    wr(8'h00, 16'h8000);
    idle(1);
    chk(led_o[0] == 1'b0, "R2 timebase enable clear", led_o[0], 0);
    wr(8'h00, 16'h8008);

    // R3: active-low polarity
    wr(8'h04, 16'h8040);
    idle(1);
    chk(led_o[0] == 1'b0, "R3 active low lit", led_o[0], 0);
    wr(8'h04, 16'h8000);
    idle(1);
    chk(led_o[0] == 1'b1, "R3 active low dark", led_o[0], 1);

    // R6: enable clear overrides force
    wr(8'h04, 16'h4040);
    idle(1);
    chk(led_o[0] == 1'b0, "R6 disabled LED inactive", led_o[0], 0);

    // R5: force lit with link down and no conditions
    link_up = 1'b0;
    wr(8'h04, 16'hC040);
    idle(1);
    chk(led_o[0] == 1'b1, "R5 force lit", led_o[0], 1);
    wr(8'h04, 16'h0000);

    // R4 / R12: table walk over LEDs via base+2*i addressing
    for (int k = 0; k < 12; k++) begin
      int li;
      li = k % 3;
      link_up = VEC[k][7];
      link_speed = VEC[k][6:5];
      full_duplex = VEC[k][4];
      wr(8'h04 + 8'(2 * li), VEC[k][23:8]);
      idle(1);
      chk(led_o[li] == VEC[k][3], "R4 R12 steady condition", led_o[li], VEC[k][3]);
    end
    wr(8'h04, 16'h0000); wr(8'h06, 16'h0000); wr(8'h08, 16'h0000);

    // R7: flash cycle in fast timer mode, period 3 lit 2
    wr(8'h00, 16'h800C);
    wr(8'h01, 16'd3);
    wr(8'h02, 16'd2);
    wr(8'h06, 16'hC000);
    wr(8'h07, 16'h0002);
    idle(2);
    // unselected event ignored (rx at 10 on LED1)
    @(negedge clk); rx_act = 4'b0001;
    @(negedge clk); rx_act = 4'b0000;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk(led_o[1] == 1'b0, "R7 unselected event ignored", led_o[1], 0);
    end
    flash_exp4 = '{2'd1, 2'd1, 2'd0, 2'd0};
    @(negedge clk); rx_act = 4'b0100;
    @(negedge clk); rx_act = 4'b0000;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk(led_o[1] == flash_exp4[j][0], "R7 flash lit then dark", led_o[1], flash_exp4[j][0]);
    end

    // R7: flash overrides steady lit (LED2, link 1000, tx 2500 selected)
    link_up = 1'b1; link_speed = 2'd2;
    wr(8'h08, 16'hC001);
    wr(8'h09, 16'h0400);
    idle(2);
    chk(led_o[2] == 1'b1, "R7 steady before flash", led_o[2], 1);
    flash_exp4 = '{2'd1, 2'd1, 2'd0, 2'd1};
    @(negedge clk); tx_act = 4'b1000;
    @(negedge clk); tx_act = 4'b0000;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk(led_o[2] == flash_exp4[j][0], "R7 flash overrides steady", led_o[2], flash_exp4[j][0]);
    end
    wr(8'h08, 16'h0000); wr(8'h09, 16'h0000);

    // R8: events on two consecutive edges, period 4 lit 2
    wr(8'h01, 16'd4);
    wr(8'h02, 16'd2);
    idle(3);
    ext9 = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
    @(negedge clk); rx_act = 4'b0100;
    @(negedge clk);
    @(negedge clk); rx_act = 4'b0000;
    chk(led_o[1] == ext9[0], "R8 extension sample 0", led_o[1], ext9[0]);
    for (int j = 1; j < 9; j++) begin
      @(negedge clk);
      chk(led_o[1] == ext9[j], "R8 extension no phase restart", led_o[1], ext9[j]);
    end
    wr(8'h06, 16'h0000); wr(8'h07, 16'h0000);

    // R9: force flash, period 2 lit 1, alternates each clock in fast mode
    wr(8'h01, 16'd2);
    wr(8'h02, 16'd1);
    wr(8'h04, 16'hC000);
    wr(8'h05, 16'h0200);
    idle(3);
    prev = led_o[0];
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      chk(led_o[0] != prev, "R9 force flash toggles", led_o[0], !prev);
      prev = led_o[0];
    end

    // R10: prescaled timebase, lit run equals TICK_UNIT clocks
    wr(8'h00, 16'h8008);
    idle(2);
    while (led_o[0] != 1'b1) @(negedge clk);
    while (led_o[0] != 1'b0) @(negedge clk);
    while (led_o[0] != 1'b1) @(negedge clk);
    run_len = 0;
    while (led_o[0] == 1'b1) begin
      run_len++;
      @(negedge clk);
    end
    chk(run_len == TU, "R10 unit length", run_len, TU);
    // R10: dark run after the lit run also lasts one unit
    run_len = 0;
    while (led_o[0] == 1'b0) begin
      run_len++;
      @(negedge clk);
    end
    chk(run_len == TU, "R10 dark unit length", run_len, TU);

    done = 1'b1;
    finish_run();
  end
endmodule